// File: doc/BRIEF.md
# Biphase frame serial transmitter

This block turns a queue of bytes into a self-clocking biphase line signal for a terminal-to-controller coaxial link. Each transmission opens with a code violation that no data bit can produce, carries one frame per queued byte, and closes with a protocol-specific tail. A strobe at twice the bit rate paces the line. The block therefore works in half-bit slots, and the output changes only on clocks where the strobe is high.

Two polarity conventions are selectable. In the primary convention frames follow one another back to back. In the alternate convention every driven level is inverted, a programmable run of fill bits separates frames, three fill bits always close the message, and the line then stays driven for a programmable hold time. The convention, fill count and hold time are captured when a transmission starts. Bytes arrive over a valid/ready port into a small queue, and a transmission lasts as long as the queue still holds a byte at each frame boundary.

Top module: `biphase_frame_tx`

## Requirements
- R1: After reset and whenever no transmission is active, line_drive, busy and line_out are 0. Half-bit strobes that arrive while the queue is empty start nothing.
- R2: A transmission starts on the first half_tick at which the queue is non-empty. Its first six half-bit slots form the code violation: three slots low, then three slots high (primary levels). busy and line_drive rise with the first slot.
- R3: In the primary convention a data 1 is sent as a low half followed by a high half, and a data 0 as a high half followed by a low half. line_out, line_drive and busy change only on clocks where half_tick is 1.
- R4: With mode_alt = 1, every driven half-bit slot (violation, frames, fill, tail) has the inverse of the level the primary convention gives it.
- R5: Each frame is 10 bits: a sync bit of 1, then the eight data bits least significant first, then a parity bit that makes the number of ones in the data and parity bits even.
- R6: In the primary convention, the next frame follows immediately while the queue still holds a byte when a frame ends. The message ends at the first frame boundary where the queue is empty.
- R7: With mode_alt = 1, fill_bits data-0 bits are sent between consecutive frames. A fill_bits value below 3 is treated as 3.
- R8: The primary tail is a data 0, then one whole bit time high, then one whole bit time low (half slots high, low, high, high, low, low).
- R9: The alternate tail is exactly three data-0 bits whatever fill_bits holds. It is followed by hold_halves half-bit slots at primary level low, which is line level high.
- R10: busy and line_drive stay 1 from the first violation slot through the last tail or hold slot. Both fall on the next half_tick, and line_out is then 0.
- R11: mode_alt, fill_bits and hold_halves are sampled on the starting strobe. Changing them during a transmission does not alter it.
- R12: in_ready is 1 exactly when the queue (depth QUEUE_DEPTH, default 4) is not full. Bytes are taken when in_valid and in_ready are both 1, and are sent in arrival order. A byte offered while the queue is full is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_data | input | 8 | Byte to queue |
| in_valid | input | 1 | in_data holds a byte |
| in_ready | output | 1 | Queue can take a byte |
| mode_alt | input | 1 | 0 primary convention, 1 inverted convention with fill and hold |
| fill_bits | input | 8 | Fill bits between frames in the inverted convention (minimum 3) |
| hold_halves | input | 8 | Hold time after the inverted tail, in half-bit slots |
| half_tick | input | 1 | Strobe at twice the bit rate |
| line_out | output | 1 | Serial biphase line level |
| line_drive | output | 1 | Line driver enable |
| busy | output | 1 | Transmission in progress |

## Verification
The bench compares every half-bit slot of whole messages against a stream that it builds from the requirements. A wrong parity sense, bit order or sync value shows up as a slot mismatch inside a frame. A tail that swaps the two whole-bit levels, or that reuses fill_bits after the last frame, makes the message the wrong length or puts the wrong levels in its last slots. Fill values below the minimum, a hold of zero, a full queue that must drop an extra byte, and configuration changed partway through a message are each driven on purpose. A design that skips the clamp, holds for one slot too many, overruns the queue or reads live configuration would send a stream of the wrong length or wrong levels.

// File: rtl/bptx_pkg.sv
// Shared definitions for the biphase frame transmitter.
// Assumes half-bit slot numbering starting at 0 within each segment.
package bptx_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_VIOL,
        S_FRAME,
        S_FILL,
        S_TAIL,
        S_HOLD,
        S_DONE
    } seq_state_t;

    localparam int VIOL_HALVES = 6;
    localparam int TAIL_HALVES = 6;
    localparam int MIN_FILL    = 3;

    // Primary-convention level of each tail slot; alternate tail is three data-0 bits.
    function automatic logic tail_level(input logic alt, input logic [2:0] idx);
        logic lvl;
        if (alt) begin
            lvl = ~idx[0];
        end else begin
            case (idx)
                3'd0:    lvl = 1'b1;
                3'd1:    lvl = 1'b0;
                3'd2:    lvl = 1'b1;
                3'd3:    lvl = 1'b1;
                default: lvl = 1'b0;
            endcase
        end
        return lvl;
    endfunction

endpackage

// File: rtl/bptx_fifo.sv
// Byte queue in front of the serializer.
// Pushes beyond DEPTH and pops from empty are ignored. Read data is taken from the head without a delay.
module bptx_fifo #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 4,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             rd_en,
    output logic [WIDTH-1:0] rd_data,
    output logic             full,
    output logic             empty,
    output logic [CW-1:0]    count
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wr_ptr;
    logic [AW-1:0]    rd_ptr;
    logic [CW-1:0]    level;
    logic             push_ok;
    logic             pop_ok;

    assign full    = (level == CW'(DEPTH));
    assign empty   = (level == '0);
    assign push_ok = wr_en && !full;
    assign pop_ok  = rd_en && !empty;
    assign rd_data = mem[rd_ptr];
    assign count   = level;

    // Store an accepted byte.
    always_ff @(posedge clk) begin
        if (push_ok) begin
            mem[wr_ptr] <= wr_data;
        end
    end

    // Advance pointers and occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            level  <= '0;
        end else begin
            if (push_ok) begin
                wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + AW'(1);
            end
            if (pop_ok) begin
                rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + AW'(1);
            end
            case ({push_ok, pop_ok})
                2'b10:   level <= level + CW'(1);
                2'b01:   level <= level - CW'(1);
                default: level <= level;
            endcase
        end
    end

endmodule

// File: rtl/bptx_frame_slot.sv
// Primary-convention level of one half-bit slot inside a frame.
// Frame bits: sync 1, data LSB first, even parity. A data 1 is low then high.
// Assumes half_idx stays below 2*(DATA_W+2).
module bptx_frame_slot #(
    parameter int DATA_W = 8,
    parameter int IDX_W  = 5
) (
    input  logic [DATA_W-1:0] data,
    input  logic [IDX_W-1:0]  half_idx,
    output logic              raw_level
);
    localparam int FRAME_BITS = DATA_W + 2;

    logic [FRAME_BITS-1:0] frame_word;
    logic [IDX_W-1:0]      bit_sel;
    logic                  bit_val;

    assign frame_word = {^data, data, 1'b1};
    assign bit_sel    = half_idx >> 1;

    // Pick the frame bit addressed by the slot.
    always_comb begin
        bit_val = 1'b0;
        for (int i = 0; i < FRAME_BITS; i++) begin
            if (bit_sel == IDX_W'(i)) begin
                bit_val = frame_word[i];
            end
        end
    end

    // First half carries the complement, second half the bit.
    assign raw_level = half_idx[0] ? bit_val : ~bit_val;

endmodule

// File: rtl/bptx_sequencer.sv
// Slot sequencer. On each half_tick it emits one half-bit slot and steps through
// violation, frames, fill, tail and hold. Configuration is latched when a message starts.
// Assumes the queue only empties through pop.
module bptx_sequencer
    import bptx_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int FILL_W = 8,
    parameter int HOLD_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              half_tick,
    input  logic              q_empty,
    input  logic [DATA_W-1:0] q_data,
    input  logic              mode_in,
    input  logic [FILL_W-1:0] fill_in,
    input  logic [HOLD_W-1:0] hold_in,
    output logic              pop,
    output logic              line_out,
    output logic              line_drive,
    output logic              mode_q_o
);
    localparam int FRAME_HALVES = 2 * (DATA_W + 2);
    localparam int IDX_W  = $clog2(FRAME_HALVES + 1);
    localparam int CW_A   = FILL_W + 1;
    localparam int CW_B   = (CW_A > HOLD_W) ? CW_A : HOLD_W;
    localparam int CNT_W  = (CW_B > IDX_W) ? CW_B : IDX_W;

    seq_state_t        state, state_n;
    logic [CNT_W-1:0]  cnt, cnt_n;
    logic [DATA_W-1:0] frame_q;
    logic              mode_q;
    logic [FILL_W-1:0] fill_q;
    logic [HOLD_W-1:0] hold_q;
    logic              line_q, drive_q;
    logic              raw_lvl, frame_raw, want_pop, start;
    logic              drive_n, mode_eff;
    logic [FILL_W-1:0] fill_clamped;
    logic [CNT_W-1:0]  fill_last, hold_last;

    bptx_frame_slot #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_slot (
        .data      (frame_q),
        .half_idx  (cnt[IDX_W-1:0]),
        .raw_level (frame_raw)
    );

    assign fill_clamped = (fill_in < FILL_W'(MIN_FILL)) ? FILL_W'(MIN_FILL) : fill_in;
    assign fill_last    = CNT_W'({fill_q, 1'b0}) - CNT_W'(1);
    assign hold_last    = CNT_W'(hold_q) - CNT_W'(1);

    // Choose the slot level and next position.
    always_comb begin
        state_n  = state;
        cnt_n    = cnt + CNT_W'(1);
        raw_lvl  = 1'b0;
        want_pop = 1'b0;
        start    = 1'b0;
        case (state)
            S_IDLE: begin
                cnt_n = '0;
                if (!q_empty) begin
                    start   = 1'b1;
                    raw_lvl = 1'b0;
                    state_n = S_VIOL;
                    cnt_n   = CNT_W'(1);
                end
            end
            S_VIOL: begin
                raw_lvl = (cnt >= CNT_W'(VIOL_HALVES / 2));
                if (cnt == CNT_W'(VIOL_HALVES - 1)) begin
                    state_n  = S_FRAME;
                    cnt_n    = '0;
                    want_pop = 1'b1;
                end
            end
            S_FRAME: begin
                raw_lvl = frame_raw;
                if (cnt == CNT_W'(FRAME_HALVES - 1)) begin
                    cnt_n = '0;
                    if (q_empty) begin
                        state_n = S_TAIL;
                    end else if (mode_q) begin
                        state_n = S_FILL;
                    end else begin
                        state_n  = S_FRAME;
                        want_pop = 1'b1;
                    end
                end
            end
            S_FILL: begin
                raw_lvl = ~cnt[0];
                if (cnt == fill_last) begin
                    state_n  = S_FRAME;
                    cnt_n    = '0;
                    want_pop = 1'b1;
                end
            end
            S_TAIL: begin
                raw_lvl = tail_level(mode_q, cnt[2:0]);
                if (cnt == CNT_W'(TAIL_HALVES - 1)) begin
                    cnt_n   = '0;
                    state_n = (mode_q && (hold_q != '0)) ? S_HOLD : S_DONE;
                end
            end
            S_HOLD: begin
                raw_lvl = 1'b0;
                if (cnt == hold_last) begin
                    state_n = S_DONE;
                    cnt_n   = '0;
                end
            end
            default: begin
                state_n = S_IDLE;
                cnt_n   = '0;
            end
        endcase
    end

    assign drive_n  = start || ((state != S_IDLE) && (state != S_DONE));
    assign mode_eff = start ? mode_in : mode_q;
    assign pop      = half_tick && want_pop;

    // Register slot outputs, position and latched configuration on each strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= S_IDLE;
            cnt     <= '0;
            frame_q <= '0;
            mode_q  <= 1'b0;
            fill_q  <= FILL_W'(MIN_FILL);
            hold_q  <= '0;
            line_q  <= 1'b0;
            drive_q <= 1'b0;
        end else if (half_tick) begin
            state   <= state_n;
            cnt     <= cnt_n;
            drive_q <= drive_n;
            line_q  <= drive_n ? (raw_lvl ^ mode_eff) : 1'b0;
            if (start) begin
                mode_q <= mode_in;
                fill_q <= fill_clamped;
                hold_q <= hold_in;
            end
            if (want_pop) begin
                frame_q <= q_data;
            end
        end
    end

    assign line_out   = line_q;
    assign line_drive = drive_q;
    assign mode_q_o   = mode_q;

endmodule

// File: rtl/biphase_frame_tx.sv
// Biphase frame serial transmitter top: byte queue plus slot sequencer.
// Assumes half_tick is a one-clock strobe at twice the bit rate.
module biphase_frame_tx #(
    parameter int DATA_W      = 8,
    parameter int QUEUE_DEPTH = 4,
    parameter int FILL_W      = 8,
    parameter int HOLD_W      = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic              mode_alt,
    input  logic [FILL_W-1:0] fill_bits,
    input  logic [HOLD_W-1:0] hold_halves,
    input  logic              half_tick,
    output logic              line_out,
    output logic              line_drive,
    output logic              busy
);
    localparam int QCNT_W = $clog2(QUEUE_DEPTH + 1);

    logic              q_full, q_empty, q_pop, mode_q;
    logic [DATA_W-1:0] q_data;
    logic [QCNT_W-1:0] q_count;

    bptx_fifo #(.WIDTH(DATA_W), .DEPTH(QUEUE_DEPTH), .CW(QCNT_W)) u_queue (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (in_valid),
        .wr_data (in_data),
        .rd_en   (q_pop),
        .rd_data (q_data),
        .full    (q_full),
        .empty   (q_empty),
        .count   (q_count)
    );

    bptx_sequencer #(.DATA_W(DATA_W), .FILL_W(FILL_W), .HOLD_W(HOLD_W)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .half_tick  (half_tick),
        .q_empty    (q_empty),
        .q_data     (q_data),
        .mode_in    (mode_alt),
        .fill_in    (fill_bits),
        .hold_in    (hold_halves),
        .pop        (q_pop),
        .line_out   (line_out),
        .line_drive (line_drive),
        .mode_q_o   (mode_q)
    );

    assign in_ready = !q_full;
    assign busy     = line_drive;

endmodule

// File: rtl/biphase_frame_tx_chk.sv
// Property checker for the biphase frame transmitter, bound to the top.
module biphase_frame_tx_chk #(
    parameter int CW    = 3,
    parameter int DEPTH = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          half_tick,
    input logic          line_out,
    input logic          line_drive,
    input logic          in_valid,
    input logic          in_ready,
    input logic [CW-1:0] q_count,
    input logic          q_pop,
    input logic          mode_q
);

    // R3
    stable_between_ticks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !half_tick |=> ($stable(line_out) && $stable(line_drive)));

    // R2
    start_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(line_drive) |-> (line_out == mode_q));

    // R10
    release_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !line_drive |-> !line_out);

    // R12
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q_count <= CW'(DEPTH));

    // R12
    ready_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && !q_pop && (q_count == CW'(DEPTH - 1))) |=> !in_ready);

    // R6
    no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q_pop |-> (q_count != '0));

endmodule

bind biphase_frame_tx biphase_frame_tx_chk #(.CW(QCNT_W), .DEPTH(QUEUE_DEPTH)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .half_tick  (half_tick),
    .line_out   (line_out),
    .line_drive (line_drive),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .q_count    (q_count),
    .q_pop      (q_pop),
    .mode_q     (mode_q)
);

// File: tb/biphase_frame_tx_bench.sv
module biphase_frame_tx_bench;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [7:0] in_data;
    logic       in_valid;
    logic       in_ready;
    logic       mode_alt;
    logic [7:0] fill_bits;
    logic [7:0] hold_halves;
    logic       half_tick;
    logic       line_out;
    logic       line_drive;
    logic       busy;

    int checks = 0;
    int fails  = 0;

    logic       exp_lvl [0:1023];
    int         exp_req [0:1023];
    int         n_exp;
    logic [7:0] bytes_q [4];

    always #10 clk = ~clk;

    biphase_frame_tx u_biphase_frame_tx (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_data     (in_data),
        .in_valid    (in_valid),
        .in_ready    (in_ready),
        .mode_alt    (mode_alt),
        .fill_bits   (fill_bits),
        .hold_halves (hold_halves),
        .half_tick   (half_tick),
        .line_out    (line_out),
        .line_drive  (line_drive),
        .busy        (busy)
    );

    // Fields: mode, byte count, three bytes, fill, hold, expected half-bit slots.
    localparam int NV = 6;
    localparam logic [50:0] VECS [NV] = '{
        {1'b0, 2'd1, 8'hA5, 8'h00, 8'h00, 8'd0, 8'd0, 8'd32},
        {1'b0, 2'd3, 8'h00, 8'hFF, 8'h3C, 8'd3, 8'd0, 8'd72},
        {1'b1, 2'd1, 8'h5A, 8'h00, 8'h00, 8'd3, 8'd4, 8'd36},
        {1'b1, 2'd2, 8'h01, 8'h80, 8'h00, 8'd5, 8'd0, 8'd62},
        {1'b1, 2'd3, 8'h7E, 8'hC3, 8'h12, 8'd1, 8'd2, 8'd86},
        {1'b0, 2'd2, 8'h96, 8'h69, 8'h00, 8'd9, 8'd7, 8'd52}
    };

    task automatic check(input bit ok, input int req, input int act, input int expv, input string what);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL R%0d %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    task automatic add_half(input logic l, input int req);
        exp_lvl[n_exp] = l;
        exp_req[n_exp] = req;
        n_exp++;
    endtask

    // R3 data 1 is low then high, data 0 high then low
    task automatic add_bit(input logic v, input int req);
        add_half(~v, req);
        add_half(v, req);
    endtask

    // Expected line stream from the requirements (R2 R5 R7 R8 R9, inverted per R4).
    task automatic build(input logic m, input int n, input int f, input int h);
        n_exp = 0;
        repeat (3) add_half(1'b0, 2);
        repeat (3) add_half(1'b1, 2);
        for (int fr = 0; fr < n; fr++) begin
            add_bit(1'b1, 5);
            for (int i = 0; i < 8; i++) add_bit(bytes_q[fr][i], 5);
            add_bit(^bytes_q[fr], 5);
            if (m && fr < n - 1) begin
                for (int k = 0; k < ((f < 3) ? 3 : f); k++) add_bit(1'b0, 7);
            end
        end
        if (!m) begin
            add_bit(1'b0, 8);
            add_half(1'b1, 8); add_half(1'b1, 8);
            add_half(1'b0, 8); add_half(1'b0, 8);
        end else begin
            repeat (3) add_bit(1'b0, 9);
            repeat (h) add_half(1'b0, 9);
            for (int i = 0; i < n_exp; i++) exp_lvl[i] = ~exp_lvl[i];
        end
    endtask

    task automatic tick();
        @(negedge clk) half_tick = 1'b1;
        @(negedge clk) half_tick = 1'b0;
    endtask

    task automatic push(input logic [7:0] b);
        @(negedge clk);
        in_data  = b;
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    // Run one message and compare every slot; chg_at alters live config (R11).
    task automatic run_tx(input logic m, input int n, input int f, input int h,
                          input int exp_halves, input int chg_at, input bit do_push);
        int  k;
        logic lv;
        mode_alt    = m;
        fill_bits   = 8'(f);
        hold_halves = 8'(h);
        if (do_push) begin
            for (int i = 0; i < n; i++) push(bytes_q[i]);
        end
        build(m, n, f, h);
        check(n_exp == exp_halves, 10, n_exp, exp_halves, "model length");
        k = 0;
        tick();
        while (busy === 1'b1 && k < 1000) begin
            check(line_out === exp_lvl[k] && line_drive === 1'b1, exp_req[k],
                  int'(line_out), int'(exp_lvl[k]), $sformatf("slot %0d mode %0d", k, m));
            lv = line_out;
            @(negedge clk);
            @(negedge clk);
            // R3 no change without a strobe
            check(line_out === lv, 3, int'(line_out), int'(lv), "hold between strobes");
            k++;
            if (k == chg_at) begin
                mode_alt    = ~m;
                fill_bits   = 8'd0;
                hold_halves = 8'd0;
            end
            tick();
        end
        // R10 release after last slot
        check(k == exp_halves, 10, k, exp_halves, "message length");
        check(line_drive === 1'b0 && busy === 1'b0 && line_out === 1'b0, 10,
              int'(line_drive), 0, "release");
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        $display("FAIL R10 watchdog: actual hung expected done");
        $display("== %0d vectors applied, %0d miscompares ==", checks + 1, fails + 1);
        $finish;
    end

    initial begin
        logic [50:0] v;
        rst_n = 1'b0; in_valid = 1'b0; in_data = 8'h00;
        mode_alt = 1'b0; fill_bits = 8'd3; hold_halves = 8'd0; half_tick = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check(line_drive === 1'b0 && busy === 1'b0 && line_out === 1'b0, 1,
              int'(line_drive), 0, "reset outputs");
        // R12 empty queue is ready
        check(in_ready === 1'b1, 12, int'(in_ready), 1, "ready after reset");

        // R1 strobes with empty queue start nothing
        repeat (4) tick();
        check(busy === 1'b0 && line_drive === 1'b0, 1, int'(busy), 0, "idle on empty queue");

        // Table of messages: R2 R4 R5 R6 R7 R8 R9
        for (int i = 0; i < NV; i++) begin
            v = VECS[i];
            bytes_q[0] = v[47:40];
            bytes_q[1] = v[39:32];
            bytes_q[2] = v[31:24];
            run_tx(v[50], int'(v[49:48]), int'(v[23:16]), int'(v[15:8]), int'(v[7:0]), -1, 1'b1);
        end

        // R12 full queue drops the extra byte, order kept
        bytes_q[0] = 8'h11; bytes_q[1] = 8'h22; bytes_q[2] = 8'h44; bytes_q[3] = 8'h88;
        for (int i = 0; i < 4; i++) push(bytes_q[i]);
        check(in_ready === 1'b0, 12, int'(in_ready), 0, "ready low when full");
        push(8'hEE);
        run_tx(1'b0, 4, 3, 0, 92, -1, 1'b0);
        check(in_ready === 1'b1, 12, int'(in_ready), 1, "ready after drain");

        // R11 live config change mid-message, including during fill
        bytes_q[0] = 8'h3C; bytes_q[1] = 8'hA1;
        run_tx(1'b1, 2, 4, 3, 63, 25, 1'b1);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule